// File: doc/BRIEF.md
# Timer Channel Interrupt Controller

This block collects expiry pulses from five timer channels and turns them into one level interrupt line per channel. A single register word holds both the per-channel enable field and the per-channel pending status field. An expiry pulse always records itself in the pending field. It raises the channel's interrupt line only if that channel is enabled in the same cycle.

Software reads the word at any time. A write does two things at once: it loads the enable field from the low bits, and it clears every pending bit that is written with a 1. An interrupt line falls only when software clears its pending bit. Changing an enable afterwards neither raises nor lowers a line. A pending bit left over from a disabled expiry does not raise the line when the channel is enabled later. The line rises only on the next expiry that happens while the channel is enabled.

Top module: `tirq_ctrl`

## Requirements
- R1: After reset the read word is 0 and every interrupt line is low.
- R2: In the read word, bit n (0..4) is channel n's enable and bit 5+n is channel n's pending status.
- R3: An expiry pulse on channel n sets pending bit 5+n on the next clock edge, whether or not the channel is enabled.
- R4: An expiry pulse on channel n raises interrupt line n on the next clock edge only if enable bit n is already set in that cycle; otherwise the line stays low.
- R5: A write loads enable bits [4:0] with the written bits [4:0].
- R6: A write clears each pending bit whose written bit [9:5] is 1 and leaves the pending bits written with 0 unchanged.
- R7: Interrupt line n falls on the clock edge where a write clears pending bit n. Enabling a channel whose pending bit is already set does not raise its line.
- R8: When an expiry and a clearing write hit the same channel in the same cycle, the pending bit stays set.
- R9: Bits 31:10 read as 0, and writes to them have no effect.
- R10: Clearing an enable bit does not lower an interrupt line that is already high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| expire_i | input | 5 | Per-channel expiry pulses, one cycle each |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Register read value |
| irq_o | output | 5 | Per-channel level interrupt lines |

## Verification
Every state element is one register stage. Enables, pending bits and interrupt lines therefore all change at the clock edge that follows the stimulus cycle, and the read word follows them with no further delay. The bench drives inputs on the falling edge and holds them for exactly one cycle. It samples the outputs on the next falling edge, half a cycle after the edge that captured the stimulus. The same-cycle cases (expiry with a clearing write, expiry with a changing enable) use this one-edge timing to tell apart which value was in effect.

// File: rtl/tirq_pkg.sv
package tirq_pkg;
  // Pending bit position for channel n in the register word.
  function automatic int stat_pos(input int n, input int num_ch);
    return num_ch + n;
  endfunction
endpackage

// File: rtl/tirq_chan.sv
module tirq_chan (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic wr_en_i,
  input  logic wr_en_bit_i,
  input  logic wr_clr_i,
  output logic en_o,
  output logic stat_o,
  output logic irq_o
);
  logic clr_hit;
  assign clr_hit = wr_en_i && wr_clr_i && !expire_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= 1'b0;
      stat_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      if (wr_en_i) en_o <= wr_en_bit_i;
      if (expire_i)     stat_o <= 1'b1;
      else if (clr_hit) stat_o <= 1'b0;
      // Enable sampled before any same-cycle write takes effect.
      if (expire_i && en_o)        irq_o <= 1'b1;
      else if (clr_hit && stat_o)  irq_o <= 1'b0;
    end
  end

  assert_exp_sets_stat_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> stat_o);
  assert_exp_en_irq_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && en_o) |=> irq_o);
  assert_irq_only_on_exp_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_o && !(expire_i && en_o)) |=> !irq_o);
  assert_en_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (en_o == $past(wr_en_bit_i)));
  assert_clr_stat_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_clr_i && !expire_i) |=> !stat_o);
  assert_clr_irq_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_clr_i && !expire_i) |=> !irq_o);
  assert_irq_needs_stat_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> stat_o);
  assert_exp_beats_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && wr_en_i && wr_clr_i) |=> stat_o);
  assert_irq_holds_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !(wr_en_i && wr_clr_i)) |=> irq_o);
endmodule

// File: rtl/tirq_pack.sv
module tirq_pack #(
  parameter int NUM_CH = 5,
  parameter int DATA_W = 32
) (
  input  logic [NUM_CH-1:0] en_i,
  input  logic [NUM_CH-1:0] stat_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int USED_W = 2 * NUM_CH;

  always_comb begin
    rd_data_o = '0;
    rd_data_o[USED_W-1:0] = {stat_i, en_i};
  end
endmodule

// File: rtl/tirq_ctrl.sv
module tirq_ctrl #(
  parameter int NUM_CH = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] expire_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [NUM_CH-1:0] irq_o
);
  import tirq_pkg::*;

  localparam int USED_W = 2 * NUM_CH;

  logic [NUM_CH-1:0] en_q;
  logic [NUM_CH-1:0] stat_q;
  logic unused_hi;
  assign unused_hi = ^wr_data_i[DATA_W-1:USED_W];

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    tirq_chan u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .expire_i   (expire_i[n]),
      .wr_en_i    (wr_en_i),
      .wr_en_bit_i(wr_data_i[n]),
      .wr_clr_i   (wr_data_i[stat_pos(n, NUM_CH)]),
      .en_o       (en_q[n]),
      .stat_o     (stat_q[n]),
      .irq_o      (irq_o[n])
    );
  end

  tirq_pack #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_pack (
    .en_i     (en_q),
    .stat_i   (stat_q),
    .rd_data_o(rd_data_o)
  );

  assert_rd_layout_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (rd_data_o[NUM_CH-1:0] == $past(wr_data_i[NUM_CH-1:0])));
  assert_hi_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_en_i) |-> ($countones(rd_data_o) <= USED_W));
endmodule

// File: tb/sim_tirq_ctrl.sv
module sim_tirq_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  expire_i = '0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic [4:0]  irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  tirq_ctrl u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .expire_i(expire_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // One-cycle stimulus; returns on the next falling edge.
  task automatic step(input logic [4:0] ex, input logic wr, input logic [31:0] d);
    @(negedge clk_i);
    expire_i = ex; wr_en_i = wr; wr_data_i = d;
    @(negedge clk_i);
    expire_i = '0; wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic t_reset;
    chk("R1 rd", rd_data_o, 32'h0);
    chk("R1 irq", {27'b0, irq_o}, 32'h0);
  endtask

  task automatic t_enable_write;
    step(5'h00, 1'b1, 32'h15);
    chk("R5 R2 enables", rd_data_o, 32'h15);
    step(5'h00, 1'b1, 32'hFFFF_FC0A);
    chk("R9 upper bits ignored", rd_data_o, 32'h0A);
  endtask

  task automatic t_expiry;
    step(5'h03, 1'b0, 32'h0);
    chk("R3 R2 status set", rd_data_o, 32'h6A);
    chk("R4 irq only enabled", {27'b0, irq_o}, 32'h02);
  endtask

  task automatic t_enable_change;
    step(5'h00, 1'b1, 32'h00);
    chk("R10 irq held after disable", {27'b0, irq_o}, 32'h02);
    chk("R5 rd after disable", rd_data_o, 32'h60);
    step(5'h00, 1'b1, 32'h01);
    chk("R7 no raise on late enable", {27'b0, irq_o}, 32'h02);
  endtask

  task automatic t_clear;
    step(5'h00, 1'b1, 32'h41);
    chk("R6 clear one keep other", rd_data_o, 32'h21);
    chk("R7 irq low after clear", {27'b0, irq_o}, 32'h00);
  endtask

  task automatic t_collision;
    step(5'h01, 1'b1, 32'h21);
    chk("R8 status stays set", rd_data_o, 32'h21);
    chk("R8 R4 irq raised", {27'b0, irq_o}, 32'h01);
    step(5'h00, 1'b1, 32'h20);
    chk("R6 R7 clear ch0", {rd_data_o[26:0], irq_o}, 32'h0);
  endtask

  task automatic t_all;
    step(5'h00, 1'b1, 32'h1F);
    step(5'h1F, 1'b0, 32'h0);
    chk("R3 all status", rd_data_o, 32'h3FF);
    chk("R4 all irq", {27'b0, irq_o}, 32'h1F);
    step(5'h00, 1'b1, 32'h29F);
    chk("R6 partial clear", rd_data_o, 32'h17F);
    chk("R7 partial irq", {27'b0, irq_o}, 32'h0B);
    step(5'h00, 1'b1, 32'hFFFF_FFFF);
    chk("R9 R6 all ones write", rd_data_o, 32'h1F);
    chk("R7 all low", {27'b0, irq_o}, 32'h00);
  endtask

  task automatic t_reset_mid;
    step(5'h1F, 1'b0, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R1 rd after reset", rd_data_o, 32'h0);
    chk("R1 irq after reset", {27'b0, irq_o}, 32'h0);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_enable_write();
    t_expiry();
    t_enable_change();
    t_clear();
    t_collision();
    t_all();
    t_reset_mid();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule